// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block sits between a group of level-sensitive device interrupt lines and one processor core. When the receiver is idle and a line rises, the block records that line's number in a set of three vector data words. It then marks itself busy, raises a hard interrupt to the core and sends a one-cycle wake pulse so that a halted core resumes.

While busy, the block takes no new request: rising lines change neither the data words nor the interrupt. The busy state ends when the line that was recorded drops its level. There is no software acknowledge. Only the rising transition of a line counts as a request. A line that rose while the receiver was busy is therefore not taken later unless it falls and rises again.

Top module: `irq_vec_latch`

## Requirements
- R1: After a synchronous active-low reset, busy, the status byte, all three data words, the interrupt and the wake pulse are all zero.
- R2: A line that is high on an edge and was low on the edge before, with the receiver idle, makes busy and the interrupt 1 after that edge. The status byte then reads 0x20, with busy at bit 5 and every other bit zero.
- R3: On a latch, data word 0 takes bits 5:0 = line number, bits 10:6 = 5'b11111 and bits 63:11 = 0. For example, line 3 gives 0x7C3.
- R4: Data words 1 and 2 are loaded with zero on every latch, so they read zero at all times.
- R5: The wake output is high for exactly the one cycle after each latching edge, and is low otherwise.
- R6: While busy, rising lines are ignored: data word 0, busy and the interrupt keep their values.
- R7: While busy, the recorded line reading low on an edge clears busy and the interrupt after that edge. A drop on any other line has no effect. Data word 0 keeps its last value.
- R8: When several lines rise on the same edge while idle, the lowest-numbered one is latched.
- R9: A line that rose while busy and stays high is not latched after busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NREQ | Level-sensitive request lines |
| busy_o | output | 1 | Receiver busy |
| stat_o | output | STATW | Status byte, busy at bit BUSY_BIT |
| data0_o | output | WORDW | Vector data word 0 |
| data1_o | output | WORDW | Vector data word 1 |
| data2_o | output | WORDW | Vector data word 2 |
| irq_o | output | 1 | Hard interrupt to the core |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
Every result is due one clock after the edge that samples its cause. This holds for busy, the interrupt, the status byte, the data words and the wake pulse, because each is a single register fed straight from the request lines and the held line index. The bench changes the request lines on a falling edge and checks all outputs on the next falling edge, which places each check one rising edge after its stimulus. The vector table advances one step per cycle, so edge history carries from each entry to the next. Each entry's expectations are written against that history: rises, drops, and lines held across busy.

// File: rtl/irq_vec_latch.sv
module irq_vec_latch #(
  parameter int NREQ     = 64,
  parameter int WORDW    = 64,
  parameter int IDXW     = 6,
  parameter int TAGW     = 5,
  parameter int STATW    = 8,
  parameter int BUSY_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req_i,
  output logic             busy_o,
  output logic [STATW-1:0] stat_o,
  output logic [WORDW-1:0] data0_o,
  output logic [WORDW-1:0] data1_o,
  output logic [WORDW-1:0] data2_o,
  output logic             irq_o,
  output logic             wake_o
);
  localparam int PADW = WORDW - TAGW - IDXW;

  logic [NREQ-1:0] prev_q;
  logic [IDXW-1:0] idx_q;
  logic            busy_q;
  logic [NREQ-1:0] rise;
  logic [IDXW-1:0] pick;
  logic            hit;
  logic            lvl;

  assign rise = req_i & ~prev_q;

  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (rise[i]) begin
        pick = IDXW'(i);
        hit  = 1'b1;
      end
    end
  end

  always_comb begin
    lvl = 1'b0;
    for (int i = 0; i < NREQ; i++)
      if (idx_q == IDXW'(i)) lvl = req_i[i];
  end

  wire take = hit && !busy_q;
  wire drop = busy_q && !lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      irq_o   <= 1'b0;
      wake_o  <= 1'b0;
      data0_o <= '0;
      data1_o <= '0;
      data2_o <= '0;
    end else begin
      prev_q <= req_i;
      wake_o <= take;
      if (take) begin
        idx_q   <= pick;
        busy_q  <= 1'b1;
        irq_o   <= 1'b1;
        data0_o <= {{PADW{1'b0}}, {TAGW{1'b1}}, pick};
        data1_o <= '0;
        data2_o <= '0;
      end else if (drop) begin
        busy_q <= 1'b0;
        irq_o  <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign stat_o = STATW'(busy_q) << BUSY_BIT;
endmodule

module irq_vec_latch_chk #(
  parameter int NREQ  = 64,
  parameter int WORDW = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  req_i,
  input logic             busy_o,
  input logic [WORDW-1:0] data0_o,
  input logic [WORDW-1:0] data1_o,
  input logic [WORDW-1:0] data2_o,
  input logic             irq_o,
  input logic             wake_o
);
  logic [NREQ-1:0] seen_q;
  logic            cur_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= req_i;
  end

  always_comb begin
    cur_lvl = 1'b0;
    for (int i = 0; i < NREQ; i++)
      if (data0_o[5:0] == 6'(i)) cur_lvl = req_i[i];
  end

  // R2
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && |(req_i & ~seen_q)) |=> (busy_o && irq_o && wake_o));

  // R6
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(data0_o));

  // R5
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R7
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cur_lvl) |=> (!busy_o && !irq_o));

  // R3
  field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (data0_o[10:6] == 5'h1F && data0_o[WORDW-1:11] == '0));

  // R4
  zero_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data1_o == '0 && data2_o == '0));
endmodule

bind irq_vec_latch irq_vec_latch_chk #(.NREQ(NREQ), .WORDW(WORDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_o(busy_o),
  .data0_o(data0_o), .data1_o(data1_o), .data2_o(data2_o),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/irq_vec_latch_tb.sv
module irq_vec_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic        busy, irq, wake;
  logic [7:0]  stat;
  logic [63:0] d0, d1, d2;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_latch u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .busy_o(busy), .stat_o(stat),
    .data0_o(d0), .data1_o(d1), .data2_o(d2), .irq_o(irq), .wake_o(wake)
  );

  // {req[71:8], busy[7], wake[6], idx[5:0]}
  localparam logic [71:0] VEC [NV] = '{
    {64'h0000_0000_0000_0008, 1'b1, 1'b1, 6'd3},   // R2 R3 R5
    {64'h0000_0000_0000_0008, 1'b1, 1'b0, 6'd3},
    {64'h0000_0000_0000_0408, 1'b1, 1'b0, 6'd3},   // R6
    {64'h0000_0000_0000_0400, 1'b0, 1'b0, 6'd3},   // R7
    {64'h0000_0000_0000_0400, 1'b0, 1'b0, 6'd3},   // R9
    {64'h0000_0000_0000_0000, 1'b0, 1'b0, 6'd3},
    {64'h8000_0100_0002_0000, 1'b1, 1'b1, 6'd17},  // R8
    {64'h8000_0100_0000_0000, 1'b0, 1'b0, 6'd17},
    {64'h8000_0000_0000_0000, 1'b0, 1'b0, 6'd17},  // R9
    {64'h0000_0000_0000_0000, 1'b0, 1'b0, 6'd17},
    {64'h8000_0000_0000_0000, 1'b1, 1'b1, 6'd63},
    {64'h8000_0000_0000_0001, 1'b1, 1'b0, 6'd63},  // R6
    {64'h8000_0000_0000_0000, 1'b1, 1'b0, 6'd63},  // R7 other line drop
    {64'h0000_0000_0000_0000, 1'b0, 1'b0, 6'd63},
    {64'h0000_0000_0000_0001, 1'b1, 1'b1, 6'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " busy"}, 64'(busy), 64'd0);
    chk({tag, " stat"}, 64'(stat), 64'd0);
    chk({tag, " irq"},  64'(irq),  64'd0);
    chk({tag, " wake"}, 64'(wake), 64'd0);
    chk({tag, " d0"}, d0, 64'd0);
    chk({tag, " d1"}, d1, 64'd0);
    chk({tag, " d2"}, d2, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 post-reset idle");

    for (int v = 0; v < NV; v++) begin
      logic        eb, ew;
      logic [5:0]  ei;
      req = VEC[v][71:8];
      eb  = VEC[v][7];
      ew  = VEC[v][6];
      ei  = VEC[v][5:0];
      @(negedge clk);
      chk($sformatf("R2 R7 R9 busy v%0d", v), 64'(busy), 64'(eb));
      chk($sformatf("R2 R7 irq v%0d", v), 64'(irq), 64'(eb));
      chk($sformatf("R2 stat v%0d", v), 64'(stat), eb ? 64'h20 : 64'h0);
      chk($sformatf("R5 wake v%0d", v), 64'(wake), 64'(ew));
      chk($sformatf("R3 R6 R8 d0 v%0d", v), d0, {53'd0, 5'h1F, ei});
      chk($sformatf("R4 d1 v%0d", v), d1, 64'd0);
      chk($sformatf("R4 d2 v%0d", v), d2, 64'd0);
    end

    // R3 explicit encoding for line 3
    req = 64'h0;
    @(negedge clk);
    req = 64'h8;
    @(negedge clk);
    chk("R3 line3 encoding", d0, 64'h7C3);

    // R1 reset while busy
    rst_n = 1'b0;
    req = 64'h0;
    @(negedge clk);
    chk_idle("R1 reset while busy");
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule